// File: doc/BRIEF.md
# Address/Data Bus Demultiplexer

This block sits between a processor with a time-shared address/data bus and the rest of a system. During the address phase of a bus cycle, the processor drives the low address byte and the top address nibble on shared lines and raises an address strobe. The block passes the full 20-bit physical address to the system side while the strobe is high. It keeps that address once the strobe drops, so the system address stays steady while the shared lines move on to carry data (low byte) or status (top nibble).

The data byte passes through a bidirectional transceiver. An active-low data enable and a transmit/receive line control it. On both sides the tri-state bus is modelled as separate in, out and output-enable signals. An active-low address output enable lets the system address bus be released.

Top module: `bus_demux_front`

## Requirements
- R1: While `addr_stb_i` is 1, `sys_addr_o` equals `{top_i, mid_i, cpu_ad_i}` in the same cycle, with bit 0 taken from `cpu_ad_i[0]` and bits 19..16 taken from `top_i`.
- R2: The address is captured at every rising clock edge at which `addr_stb_i` is 1. While `addr_stb_i` is 0, `sys_addr_o` shows the value captured at the last such edge.
- R3: While `addr_stb_i` is 0, changes on `cpu_ad_i`, `mid_i` and `top_i` have no effect on `sys_addr_o`.
- R4: After reset, the held address is 0. With the strobe low, `sys_addr_o` reads 0.
- R5: `sys_addr_oe_o` is 1 exactly when `addr_oe_n_i` is 0. Releasing the address bus and enabling it again does not change the held address.
- R6: While `data_en_n_i` is 1, both `sys_d_oe_o` and `cpu_ad_oe_o` are 0.
- R7: With `data_en_n_i` 0 and `dir_tx_i` 1, `sys_d_oe_o` is 1, `sys_d_o` equals `cpu_ad_i`, and `cpu_ad_oe_o` is 0.
- R8: With `data_en_n_i` 0 and `dir_tx_i` 0, `cpu_ad_oe_o` is 1, `cpu_ad_o` equals `sys_d_i`, and `sys_d_oe_o` is 0.
- R9: `sys_d_oe_o` and `cpu_ad_oe_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_ad_i | input | 8 | Shared low address/data byte, driven by the processor |
| cpu_ad_o | output | 8 | Data driven toward the processor |
| cpu_ad_oe_o | output | 1 | Drive enable toward the processor |
| mid_i | input | 8 | Address bits 15..8 |
| top_i | input | 4 | Shared address bits 19..16 / status |
| addr_stb_i | input | 1 | Address strobe, high during the address phase |
| addr_oe_n_i | input | 1 | Active-low output enable of the address bus |
| data_en_n_i | input | 1 | Active-low transceiver enable |
| dir_tx_i | input | 1 | 1 = processor to system, 0 = system to processor |
| sys_addr_o | output | 20 | System address bus |
| sys_addr_oe_o | output | 1 | Address bus drive enable |
| sys_d_i | input | 8 | Data from the system side |
| sys_d_o | output | 8 | Data driven toward the system side |
| sys_d_oe_o | output | 1 | Drive enable toward the system side |

## Verification
The bench uses the default widths (8, 8 and 4 address bits, 8 data bits). It runs 64 arithmetic address patterns. For each one it checks the pass-through during the strobe, then the hold after the strobe falls while the shared lines carry changing data and status. It then sweeps all 256 byte values in each of the four enable/direction combinations. This covers every data bit in both transfer directions and the fully disabled state.

// File: rtl/bus_demux_pkg.sv
package bus_demux_pkg;

    typedef struct packed {
        logic to_sys;
        logic to_cpu;
    } xcvr_dir_t;

    function automatic xcvr_dir_t decode_dir(input logic en_n, input logic tx);
        xcvr_dir_t r;
        r.to_sys = ~en_n & tx;
        r.to_cpu = ~en_n & ~tx;
        return r;
    endfunction

endpackage

// File: rtl/addr_hold.sv
module addr_hold #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] hold;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb_i) st_d.hold = d_i;
        q_o = stb_i ? d_i : st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: with the strobe low at two edges in a row, the output cannot move
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_i && $past(!stb_i)) |-> $stable(q_o));

    // R2: after the strobe falls, the output shows the value seen at the last high edge
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_i) |-> (q_o == $past(d_i)));

endmodule

// File: rtl/data_xcvr.sv
module data_xcvr
    import bus_demux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         en_n_i,
    input  logic         tx_i,
    input  logic [W-1:0] cpu_i,
    output logic [W-1:0] cpu_o,
    output logic         cpu_oe_o,
    input  logic [W-1:0] sys_i,
    output logic [W-1:0] sys_o,
    output logic         sys_oe_o
);

    xcvr_dir_t dir_d;

    always_comb begin
        dir_d    = decode_dir(en_n_i, tx_i);
        sys_o    = cpu_i;
        cpu_o    = sys_i;
        sys_oe_o = dir_d.to_sys;
        cpu_oe_o = dir_d.to_cpu;
    end

endmodule

// File: rtl/bus_demux_front.sv
module bus_demux_front #(
    parameter int LO_W  = 8,
    parameter int MID_W = 8,
    parameter int TOP_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [LO_W-1:0]                cpu_ad_i,
    output logic [LO_W-1:0]                cpu_ad_o,
    output logic                           cpu_ad_oe_o,
    input  logic [MID_W-1:0]               mid_i,
    input  logic [TOP_W-1:0]               top_i,
    input  logic                           addr_stb_i,
    input  logic                           addr_oe_n_i,
    input  logic                           data_en_n_i,
    input  logic                           dir_tx_i,
    output logic [LO_W+MID_W+TOP_W-1:0]    sys_addr_o,
    output logic                           sys_addr_oe_o,
    input  logic [LO_W-1:0]                sys_d_i,
    output logic [LO_W-1:0]                sys_d_o,
    output logic                           sys_d_oe_o
);

    localparam int ADDR_W = LO_W + MID_W + TOP_W;

    logic [ADDR_W-1:0] addr_live;

    always_comb begin
        addr_live     = {top_i, mid_i, cpu_ad_i};
        sys_addr_oe_o = ~addr_oe_n_i;
    end

    addr_hold #(.W(ADDR_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (addr_stb_i),
        .d_i   (addr_live),
        .q_o   (sys_addr_o)
    );

    data_xcvr #(.W(LO_W)) u_xcvr (
        .en_n_i   (data_en_n_i),
        .tx_i     (dir_tx_i),
        .cpu_i    (cpu_ad_i),
        .cpu_o    (cpu_ad_o),
        .cpu_oe_o (cpu_ad_oe_o),
        .sys_i    (sys_d_i),
        .sys_o    (sys_d_o),
        .sys_oe_o (sys_d_oe_o)
    );

    // R9: the transceiver never drives both sides at once
    a_r9_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_d_oe_o, cpu_ad_oe_o}));

    // R6: a disabled transceiver drives neither side
    a_r6_off: assert property (@(posedge clk) disable iff (!rst_n)
        data_en_n_i |-> (!sys_d_oe_o && !cpu_ad_oe_o));

    // R7: transmit direction carries the processor byte to the system side
    a_r7_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_en_n_i && dir_tx_i) |-> (sys_d_oe_o && sys_d_o == cpu_ad_i));

    // R8: receive direction carries the system byte to the processor side
    a_r8_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_en_n_i && !dir_tx_i) |-> (cpu_ad_oe_o && cpu_ad_o == sys_d_i));

    // R1: during the strobe the system address follows the live lines
    a_r1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb_i |-> (sys_addr_o == {top_i, mid_i, cpu_ad_i}));

endmodule

// File: tb/bus_demux_front_test.sv
module bus_demux_front_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_ad_i = '0;
    logic [7:0]  cpu_ad_o;
    logic        cpu_ad_oe_o;
    logic [7:0]  mid_i = '0;
    logic [3:0]  top_i = '0;
    logic        addr_stb_i = 1'b0;
    logic        addr_oe_n_i = 1'b0;
    logic        data_en_n_i = 1'b1;
    logic        dir_tx_i = 1'b0;
    logic [19:0] sys_addr_o;
    logic        sys_addr_oe_o;
    logic [7:0]  sys_d_i = '0;
    logic [7:0]  sys_d_o;
    logic        sys_d_oe_o;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    bus_demux_front uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_ad_i(cpu_ad_i), .cpu_ad_o(cpu_ad_o), .cpu_ad_oe_o(cpu_ad_oe_o),
        .mid_i(mid_i), .top_i(top_i), .addr_stb_i(addr_stb_i),
        .addr_oe_n_i(addr_oe_n_i), .data_en_n_i(data_en_n_i), .dir_tx_i(dir_tx_i),
        .sys_addr_o(sys_addr_o), .sys_addr_oe_o(sys_addr_oe_o),
        .sys_d_i(sys_d_i), .sys_d_o(sys_d_o), .sys_d_oe_o(sys_d_oe_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [19:0] a;
        step; step;
        rst_n = 1'b1;
        step;
        #1;
        check("R4 reset address", 32'(sys_addr_o), 32'h0);
        check("R6 reset oe", 32'({sys_d_oe_o, cpu_ad_oe_o}), 32'h0);
        check("R5 addr oe on", 32'(sys_addr_oe_o), 32'h1);

        for (int i = 0; i < 64; i++) begin
            a = 20'((i * 32'h1D3B7) ^ (i << 13) ^ 32'h5A5A5);
            step;
            addr_stb_i = 1'b1;
            {top_i, mid_i, cpu_ad_i} = a;
            #1;
            check("R1 follow", 32'(sys_addr_o), 32'(a));
            step;
            addr_stb_i = 1'b0;
            cpu_ad_i = 8'(~a[7:0] + 8'(i));
            top_i = 4'(i ^ 9);
            mid_i = 8'(i * 7);
            #1;
            check("R2 held after fall", 32'(sys_addr_o), 32'(a));
            step;
            cpu_ad_i = 8'(i * 3);
            top_i = 4'(~i);
            #1;
            check("R3 data/status ignored", 32'(sys_addr_o), 32'(a));
            if (i % 16 == 5) begin
                addr_oe_n_i = 1'b1;
                #1;
                check("R5 addr released", 32'(sys_addr_oe_o), 32'h0);
                step;
                addr_oe_n_i = 1'b0;
                #1;
                check("R5 addr restored", 32'({sys_addr_oe_o, sys_addr_o}), 32'({1'b1, a}));
            end
        end

        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 256; v++) begin
                step;
                data_en_n_i = m[1];
                dir_tx_i = m[0];
                cpu_ad_i = 8'(v);
                sys_d_i = 8'(255 - v);
                #1;
                if (m[1]) begin
                    check("R6 disabled", 32'({sys_d_oe_o, cpu_ad_oe_o}), 32'h0);
                end else if (m[0]) begin
                    check("R7 tx", 32'({cpu_ad_oe_o, sys_d_oe_o, sys_d_o}), 32'({2'b01, 8'(v)}));
                end else begin
                    check("R8 rx", 32'({sys_d_oe_o, cpu_ad_oe_o, cpu_ad_o}), 32'({2'b01, 8'(255 - v)}));
                end
                check("R9 one side", 32'(sys_d_oe_o & cpu_ad_oe_o), 32'h0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule